// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a synchronous binary counter, eight bits wide by default, that steps up or down by one on each rising clock edge. It has a synchronous clear, a parallel load, and a separate count enable for each direction. All state changes happen on the rising edge. There is no asynchronous path into the count register.

Each stage drives two combinational cascade enables, one per direction. A stage's up cascade enable feeds the up enable of the next, more significant stage, and its down cascade enable feeds that stage's down enable. Clock, clear and load go to every stage in parallel. Because the carry into a stage is a single AND of registered bits and the enable, the chain adds no register stage: a wider counter built this way counts as one plain binary counter. Each stage also reports two terminal flags, all-ones and all-zeros, that ignore the enables. AND the flags of all stages to get the terminal count of the whole chain.

The pins are plain control and data pins. Nothing here moves data through a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `bidir_cascade_counter`

## Requirements
- R1: When `sync_clr` is 1 at a rising edge, the count becomes 0 whatever the other inputs are. After that edge `term_up` reads 0 and `term_dn` reads 1.
- R2: When `sync_clr` is 0 and `load` is 1 at a rising edge, the count takes the value of `din`, whatever `en_up` and `en_dn` are.
- R3: When `sync_clr` and `load` are 0, `en_up` is 1 and `en_dn` is 0, the count rises by one at the edge, wrapping from all-ones (0xFF) to 0x00.
- R4: When `sync_clr` and `load` are 0, `en_dn` is 1 and `en_up` is 0, the count falls by one at the edge, wrapping from 0x00 to all-ones (0xFF).
- R5: When `sync_clr`, `load`, `en_up` and `en_dn` are all 0, the count keeps its value across the edge.
- R6: When `sync_clr` and `load` are 0 and both `en_up` and `en_dn` are 1, the count keeps its value across the edge. The cascade outputs are not defined in that cycle.
- R7: `casc_up` is 1 exactly when every count bit is 1 and `en_up` is 1, in the same cycle, with no clock edge in between.
- R8: `casc_dn` is 1 exactly when every count bit is 0 and `en_dn` is 1, in the same cycle.
- R9: `term_up` is 1 exactly when every count bit is 1, and `term_dn` is 1 exactly when every count bit is 0. Neither flag depends on the enables.
- R10: Two stages can be chained this way: the low stage's `casc_up`/`casc_dn` drive the high stage's `en_up`/`en_dn`, and clock, clear and load are shared. The pair then counts as one 16-bit binary counter, wrapping modulo 65536. The AND of the two stages' `term_up` flags (and likewise their `term_dn` flags) gives the 16-bit terminal counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| sync_clr | input | 1 | Synchronous clear, highest priority |
| load | input | 1 | Parallel load enable |
| din | input | WIDTH | Value captured on load |
| en_up | input | 1 | Count-up enable (cascade input) |
| en_dn | input | 1 | Count-down enable (cascade input) |
| count | output | WIDTH | Registered count value |
| casc_up | output | 1 | Up enable for the next stage |
| casc_dn | output | 1 | Down enable for the next stage |
| term_up | output | 1 | Count is all ones |
| term_dn | output | 1 | Count is all zeros |

## Verification
Clear, load and count operations show on `count` one rising edge after the inputs that request them. The cascade enables and terminal flags follow their inputs and the count within the same cycle, with no edge in between. The bench applies each vector on the falling edge. It checks the combinational outputs of both chained stages a short moment after driving them, while the count they depend on is still stable. It checks the 16-bit count just after the following rising edge. In this way every result is sampled only once it is due, and away from the clock edge.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4
  } bdc_op_e;

endpackage

// File: rtl/bdc_op_decode.sv
module bdc_op_decode
  import bdc_pkg::*;
(
  input  logic    sync_clr,
  input  logic    load,
  input  logic    en_up,
  input  logic    en_dn,
  output bdc_op_e op
);

  // Fixed priority: clear, then load, then a single active direction.
  always_comb begin
    if (sync_clr)
      op = OP_CLEAR;
    else if (load)
      op = OP_LOAD;
    else if (en_up && !en_dn)
      op = OP_INC;
    else if (en_dn && !en_up)
      op = OP_DEC;
    else
      op = OP_HOLD;
  end

endmodule

// File: rtl/bdc_count_reg.sv
module bdc_count_reg
  import bdc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  bdc_op_e          op,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] nxt;

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = ZERO;
      OP_LOAD:  nxt = din;
      OP_INC:   nxt = count + ONE;
      OP_DEC:   nxt = count - ONE;
      default:  nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    count <= nxt;
  end

endmodule

// File: rtl/bdc_flag_logic.sv
module bdc_flag_logic #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] count,
  input  logic             en_up,
  input  logic             en_dn,
  output logic             casc_up,
  output logic             casc_dn,
  output logic             term_up,
  output logic             term_dn
);

  logic all_ones;
  logic all_zeros;

  // Only reductions of registered bits, so chaining adds one AND per stage.
  assign all_ones  = &count;
  assign all_zeros = ~|count;

  assign term_up = all_ones;
  assign term_dn = all_zeros;
  assign casc_up = all_ones  & en_up;
  assign casc_dn = all_zeros & en_dn;

endmodule

// File: rtl/bidir_cascade_counter.sv
module bidir_cascade_counter
  import bdc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             sync_clr,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  logic             en_up,
  input  logic             en_dn,
  output logic [WIDTH-1:0] count,
  output logic             casc_up,
  output logic             casc_dn,
  output logic             term_up,
  output logic             term_dn
);

  bdc_op_e op;

  bdc_op_decode u_decode (
    .sync_clr (sync_clr),
    .load     (load),
    .en_up    (en_up),
    .en_dn    (en_dn),
    .op       (op)
  );

  bdc_count_reg #(.WIDTH(WIDTH)) u_reg (
    .clk   (clk),
    .op    (op),
    .din   (din),
    .count (count)
  );

  bdc_flag_logic #(.WIDTH(WIDTH)) u_flags (
    .count   (count),
    .en_up   (en_up),
    .en_dn   (en_dn),
    .casc_up (casc_up),
    .casc_dn (casc_dn),
    .term_up (term_up),
    .term_dn (term_dn)
  );

endmodule

// File: rtl/bidir_cascade_counter_chk.sv
module bidir_cascade_counter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             sync_clr,
  input logic             load,
  input logic [WIDTH-1:0] din,
  input logic             en_up,
  input logic             en_dn,
  input logic [WIDTH-1:0] count,
  input logic             casc_up,
  input logic             casc_dn,
  input logic             term_up,
  input logic             term_dn
);

  localparam logic [WIDTH-1:0] ONES = '1;

  // Becomes 1 after the first clear edge; properties wait for it.
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | sync_clr;

  p_clear_r1: assert property (@(posedge clk) disable iff (!armed)
    sync_clr |=> (count == '0) && term_dn && !term_up);

  p_load_r2: assert property (@(posedge clk) disable iff (!armed)
    (!sync_clr && load) |=> (count == $past(din)));

  p_inc_r3: assert property (@(posedge clk) disable iff (!armed)
    (!sync_clr && !load && en_up && !en_dn) |=> (count == WIDTH'($past(count) + WIDTH'(1))));

  p_dec_r4: assert property (@(posedge clk) disable iff (!armed)
    (!sync_clr && !load && en_dn && !en_up) |=> (count == WIDTH'($past(count) - WIDTH'(1))));

  p_hold_r5: assert property (@(posedge clk) disable iff (!armed)
    (!sync_clr && !load && !en_up && !en_dn) |=> $stable(count));

  p_both_hold_r6: assert property (@(posedge clk) disable iff (!armed)
    (!sync_clr && !load && en_up && en_dn) |=> $stable(count));

  p_casc_up_r7: assert property (@(posedge clk) disable iff (!armed)
    casc_up |-> (term_up && en_up));

  p_casc_up_on_r7: assert property (@(posedge clk) disable iff (!armed)
    (count == ONES && en_up) |-> casc_up);

  p_casc_dn_r8: assert property (@(posedge clk) disable iff (!armed)
    casc_dn |-> (term_dn && en_dn));

  p_casc_dn_on_r8: assert property (@(posedge clk) disable iff (!armed)
    (count == '0 && en_dn) |-> casc_dn);

  p_term_up_r9: assert property (@(posedge clk) disable iff (!armed)
    term_up == (count == ONES));

  p_term_dn_r9: assert property (@(posedge clk) disable iff (!armed)
    term_dn == (count == '0));

endmodule

bind bidir_cascade_counter bidir_cascade_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .sync_clr (sync_clr),
  .load     (load),
  .din      (din),
  .en_up    (en_up),
  .en_dn    (en_dn),
  .count    (count),
  .casc_up  (casc_up),
  .casc_dn  (casc_dn),
  .term_up  (term_up),
  .term_dn  (term_dn)
);

// File: tb/bidir_cascade_counter_bench.sv
module bidir_cascade_counter_bench;

  localparam int PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic         clr = 1'b1, ld = 1'b0, up = 1'b0, dn = 1'b0;
  logic [15:0]  d16 = '0;
  logic [W-1:0] q_lo, q_hi;
  logic         cu_lo, cd_lo, tu_lo, td_lo;
  logic         cu_hi, cd_hi, tu_hi, td_hi;

  int vectors = 0;
  int fails   = 0;
  logic [15:0] model = '0;

  // Low stage
  bidir_cascade_counter #(.WIDTH(W)) u_bidir_cascade_counter (
    .clk(clk), .sync_clr(clr), .load(ld), .din(d16[7:0]),
    .en_up(up), .en_dn(dn), .count(q_lo),
    .casc_up(cu_lo), .casc_dn(cd_lo), .term_up(tu_lo), .term_dn(td_lo));

  // High stage, enabled by the low stage's cascade outputs (R10)
  bidir_cascade_counter #(.WIDTH(W)) u_bidir_cascade_counter_hi (
    .clk(clk), .sync_clr(clr), .load(ld), .din(d16[15:8]),
    .en_up(cu_lo), .en_dn(cd_lo), .count(q_hi),
    .casc_up(cu_hi), .casc_dn(cd_hi), .term_up(tu_hi), .term_dn(td_hi));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one vector on the falling edge, check the combinational outputs, then the count.
  task automatic apply(input logic c, input logic l, input logic [15:0] dv,
                       input logic u, input logic dd);
    string tag;
    @(negedge clk);
    clr = c; ld = l; d16 = dv; up = u; dn = dd;
    #1;
    chk("R9 term_up lo", {31'd0, tu_lo}, {31'd0, model[7:0] == 8'hFF});
    chk("R9 term_dn lo", {31'd0, td_lo}, {31'd0, model[7:0] == 8'h00});
    chk("R10 term_up 16", {31'd0, tu_lo & tu_hi}, {31'd0, model == 16'hFFFF});
    chk("R10 term_dn 16", {31'd0, td_lo & td_hi}, {31'd0, model == 16'h0000});
    if (!(u && dd)) begin
      chk("R7 casc_up lo", {31'd0, cu_lo}, {31'd0, (model[7:0] == 8'hFF) && u});
      chk("R8 casc_dn lo", {31'd0, cd_lo}, {31'd0, (model[7:0] == 8'h00) && dd});
      chk("R7 casc_up hi", {31'd0, cu_hi}, {31'd0, (model == 16'hFFFF) && u});
      chk("R8 casc_dn hi", {31'd0, cd_hi}, {31'd0, (model == 16'h0000) && dd});
    end
    if (c)            begin model = '0;       tag = "R1 clear"; end
    else if (l)       begin model = dv;       tag = "R2 load"; end
    else if (u && !dd) begin model = model + 16'd1; tag = "R3/R10 up"; end
    else if (dd && !u) begin model = model - 16'd1; tag = "R4/R10 down"; end
    else if (u && dd) tag = "R6 both";
    else              tag = "R5 hold";
    @(posedge clk);
    #1;
    chk(tag, {16'd0, q_hi, q_lo}, {16'd0, model});
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // Reset state (R1)
    @(posedge clk); #1;
    model = '0;
    apply(1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
    chk("R1 term_dn after clear", {31'd0, td_lo}, 32'd1);
    chk("R1 term_up after clear", {31'd0, tu_lo}, 32'd0);
    // Clear outranks load and enables (R1)
    apply(1'b0, 1'b1, 16'h1234, 1'b0, 1'b0);
    apply(1'b1, 1'b1, 16'hABCD, 1'b1, 1'b0);
    // Load ignores enables (R2)
    apply(1'b0, 1'b1, 16'h00F0, 1'b1, 1'b0);
    apply(1'b0, 1'b1, 16'h00F0, 1'b0, 1'b1);
    // Up sweep across byte boundaries (R3, R10)
    for (int i = 0; i < 600; i++) apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
    // Hold (R5)
    for (int i = 0; i < 5; i++) apply(1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
    // Both enables, low byte mid-range so the high stage sees no enable (R6)
    apply(1'b0, 1'b1, 16'h3355, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b1);
    // Down sweep across the byte boundary and through zero (R4, R10)
    apply(1'b0, 1'b1, 16'h0105, 1'b0, 1'b0);
    for (int i = 0; i < 300; i++) apply(1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
    // 16-bit wrap upward (R3, R10)
    apply(1'b0, 1'b1, 16'hFFF8, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) apply(1'b0, 1'b0, 16'h0, 1'b1, 1'b0);
    // Terminal flags with enables off (R9)
    apply(1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0);
    apply(1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
    apply(1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
    apply(1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule